// File: doc/BRIEF.md
# Host I/O Window Decoder

This block sits on the main processor's 16-bit data bus and answers a small 32-byte I/O window. On reads it presents four live input words and one live configuration word, each at a fixed word offset within the window. It also presents a foreground bank register that can be written and read back. Every other read in the window returns zero. The input words are active low, so an idle input reads as one.

On writes it handles three kinds of access:
- A write to the command offset with the upper byte lane strobed stores the upper data byte in a command latch for the sound processor. It also raises a level interrupt toward that processor, and the interrupt stays asserted until the sound side returns a one-cycle acknowledge.
- Four scroll registers and the bank register are ordinary storage, written under byte-lane control.
- One neighbouring offset takes writes and discards them.

The sound processor reads the latched byte at one address in its own space.

Top module: `hio_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the four scroll registers, the bank register and the command latch are cleared to zero, and `snd_irq` is low.
- R2: A read (`bus_rd` high) at window word offsets 0, 1, 2 and 3 returns input words 0 to 3 in the same cycle. Input word k is `pad_words[16k+15:16k]`. The value is taken live, with no register in the path.
- R3: A read at window word offset 7 (byte address base+0x0E) returns `cfg_word` in the same cycle.
- R4: A read at any other window offset except 14 returns 0x0000. This covers offsets 4, 5, 6, 8 to 13 and 15. Any address outside the window, and any cycle with `bus_rd` low, also returns 0x0000.
- R5: A write at byte address base+0x08 with `lane_hi` high loads `bus_wdata[15:8]` into the command latch at the next edge. While `snd_rd` is high, `snd_rdata` shows the latch when `snd_addr` equals 0xF800, and 0x00 at any other sound address.
- R6: A write at base+0x08 with only `lane_lo` high changes neither the latch nor `snd_irq`.
- R7: An accepted command write drives `snd_irq` high from the next cycle. It stays high until a cycle with `snd_ack` high and no new command, after which it is low.
- R8: A command write and an acknowledge in the same cycle leave `snd_irq` high and load the new byte.
- R9: A write at base+0x0A changes no register and no output. The same holds for writes to the read-only offsets 0 to 3, 6 and 7, and to offsets 12, 13 and 15.
- R10: Scroll register k (k = 0..3) lives at word offset 8+k (base+0x10+2k) and is shown on `scroll_out[16k+15:16k]`. `lane_hi` writes bits 15:8 and `lane_lo` writes bits 7:0.
- R11: The bank register at word offset 14 (base+0x1C) is written with the same byte-lane rule as R10. It is shown on `fg_bank` and read back on the bus at that offset.
- R12: Writes whose address lies outside the window change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | Main bus byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| lane_hi | input | 1 | Upper byte lane strobe (data 15:8) |
| lane_lo | input | 1 | Lower byte lane strobe (data 7:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| pad_words | input | 64 | Four active-low input words, word k at bits 16k+15:16k |
| cfg_word | input | 16 | Configuration switch word |
| snd_addr | input | 16 | Sound processor address |
| snd_rd | input | 1 | Sound processor read strobe |
| snd_ack | input | 1 | One-cycle interrupt acknowledge |
| snd_rdata | output | 8 | Command latch byte toward the sound processor |
| snd_irq | output | 1 | Held sound interrupt |
| scroll_out | output | 64 | Four scroll registers, register k at bits 16k+15:16k |
| fg_bank | output | 16 | Foreground bank register |

## Verification
The hardest case to reach from the ports is a new command landing in the same cycle as the acknowledge of the previous one. The bench first raises the interrupt with one command. It then drives a second command write and the acknowledge pulse in one bus cycle, and checks that the interrupt stays high and that the latch holds the second byte. The byte-lane rules and the ignored offsets are covered by a sweep over all sixteen window offsets and all four lane combinations, with a full state compare after every write.

// File: rtl/hio_pkg.sv
// Shared constants and decode result type for the host I/O window decoder.
// Assumes a 32-byte window (16 word offsets) on a 16-bit data bus.
package hio_pkg;
    localparam int DATA_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int OFS_W      = 4;
    localparam int NUM_PADS   = 4;
    localparam int NUM_SCROLL = 4;
    localparam int PAD_IDX_W  = $clog2(NUM_PADS);
    localparam int SCR_IDX_W  = $clog2(NUM_SCROLL);

    // Word offsets inside the window; scroll base is aligned to NUM_SCROLL.
    localparam logic [OFS_W-1:0] OFS_CFG     = 4'd7;
    localparam logic [OFS_W-1:0] OFS_CMD     = 4'd4;
    localparam logic [OFS_W-1:0] OFS_SCROLL0 = 4'd8;
    localparam logic [OFS_W-1:0] OFS_SCR_END = 4'd11;
    localparam logic [OFS_W-1:0] OFS_BANK    = 4'd14;

    typedef struct packed {
        logic                 pad_rd;
        logic [PAD_IDX_W-1:0] pad_idx;
        logic                 cfg_rd;
        logic                 bank_rd;
        logic                 cmd_wr;
        logic                 scroll_wr;
        logic [SCR_IDX_W-1:0] scroll_idx;
        logic                 bank_wr;
    } hio_hit_t;
endpackage

// File: rtl/hio_addr_decode.sv
// Address decoder: turns a bus address and strobes into one-hot access hits.
// Assumes the window base is aligned to the window size and that the scroll
// offsets start on a multiple of the scroll count. Offsets with no hit
// (including the discarded write offset) simply produce no action.
module hio_addr_decode
    import hio_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'h180000
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              lane_hi,
    output hio_hit_t          hit
);
    localparam int TAG_LSB = OFS_W + 1;

    logic             in_win;
    logic [OFS_W-1:0] wofs;
    logic             unused_lsb;

    assign unused_lsb = bus_addr[0];

    // Match the window tag and classify the word offset.
    always_comb begin
        in_win = (bus_addr[ADDR_W-1:TAG_LSB] == WIN_BASE[ADDR_W-1:TAG_LSB]);
        wofs   = bus_addr[OFS_W:1];
        hit    = '0;
        if (in_win && bus_rd) begin
            if (wofs < OFS_W'(NUM_PADS)) begin
                hit.pad_rd  = 1'b1;
                hit.pad_idx = wofs[PAD_IDX_W-1:0];
            end
            hit.cfg_rd  = (wofs == OFS_CFG);
            hit.bank_rd = (wofs == OFS_BANK);
        end
        if (in_win && bus_wr) begin
            hit.cmd_wr = (wofs == OFS_CMD) && lane_hi;
            if (wofs >= OFS_SCROLL0 && wofs <= OFS_SCR_END) begin
                hit.scroll_wr  = 1'b1;
                hit.scroll_idx = wofs[SCR_IDX_W-1:0];
            end
            hit.bank_wr = (wofs == OFS_BANK);
        end
    end
endmodule

// File: rtl/hio_reg_bank.sv
// Storage for the scroll registers and the foreground bank register.
// Each register takes byte-lane-qualified writes; reset clears all to zero.
module hio_reg_bank
    import hio_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scroll_wr,
    input  logic [SCR_IDX_W-1:0]         scroll_idx,
    input  logic                         bank_wr,
    input  logic                         lane_hi,
    input  logic                         lane_lo,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM_SCROLL*DATA_W-1:0] scroll_flat,
    output logic [DATA_W-1:0]            fg_bank
);
    // Merge new data into an old word under the two lane strobes.
    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic              hi,
        input logic              lo
    );
        logic [DATA_W-1:0] r;
        r = old_w;
        if (hi) r[DATA_W-1:BYTE_W] = new_w[DATA_W-1:BYTE_W];
        if (lo) r[BYTE_W-1:0]      = new_w[BYTE_W-1:0];
        return r;
    endfunction

    for (genvar g = 0; g < NUM_SCROLL; g++) begin : g_scroll
        logic [DATA_W-1:0] scr_q;
        // Hold one scroll word; update on a write aimed at this index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                scr_q <= '0;
            else if (scroll_wr && scroll_idx == SCR_IDX_W'(g))
                scr_q <= lane_merge(scr_q, wdata, lane_hi, lane_lo);
        end
        assign scroll_flat[g*DATA_W +: DATA_W] = scr_q;
    end

    // Hold the foreground bank word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fg_bank <= '0;
        else if (bank_wr)
            fg_bank <= lane_merge(fg_bank, wdata, lane_hi, lane_lo);
    end
endmodule

// File: rtl/hio_cmd_latch.sv
// Sound command mailbox: one byte latch plus a held interrupt line.
// A new command sets the interrupt and overrides a same-cycle acknowledge.
// The sound side sees the byte only at its own latch address while reading.
module hio_cmd_latch
    import hio_pkg::*;
#(
    parameter int                    SND_ADDR_W     = 16,
    parameter logic [SND_ADDR_W-1:0] SND_LATCH_ADDR = 16'hF800
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic [BYTE_W-1:0]     cmd_data,
    input  logic                  snd_ack,
    input  logic [SND_ADDR_W-1:0] snd_addr,
    input  logic                  snd_rd,
    output logic [BYTE_W-1:0]     cmd_byte,
    output logic [BYTE_W-1:0]     snd_rdata,
    output logic                  snd_irq
);
    // Capture the command byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_byte <= '0;
        else if (cmd_wr) cmd_byte <= cmd_data;
    end

    // Set on command, clear on acknowledge; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       snd_irq <= 1'b0;
        else if (cmd_wr)  snd_irq <= 1'b1;
        else if (snd_ack) snd_irq <= 1'b0;
    end

    // Present the byte on the sound side read port.
    always_comb begin
        snd_rdata = '0;
        if (snd_rd && snd_addr == SND_LATCH_ADDR) snd_rdata = cmd_byte;
    end
endmodule

// File: rtl/hio_read_mux.sv
// Read data selector: live input words, configuration word, bank readback.
// Produces zero when no readable offset is hit.
module hio_read_mux
    import hio_pkg::*;
(
    input  hio_hit_t                   hit,
    input  logic [NUM_PADS*DATA_W-1:0] pad_words,
    input  logic [DATA_W-1:0]          cfg_word,
    input  logic [DATA_W-1:0]          fg_bank,
    output logic [DATA_W-1:0]          rdata
);
    logic unused_wr;
    assign unused_wr = hit.cmd_wr ^ hit.scroll_wr ^ hit.bank_wr ^ (^hit.scroll_idx);

    // Select the single read source, zero otherwise.
    always_comb begin
        rdata = '0;
        if (hit.pad_rd)       rdata = pad_words[hit.pad_idx*DATA_W +: DATA_W];
        else if (hit.cfg_rd)  rdata = cfg_word;
        else if (hit.bank_rd) rdata = fg_bank;
    end
endmodule

// File: rtl/hio_decoder.sv
// Top of the host I/O window decoder. Wires the address decoder, the register
// storage, the sound command mailbox and the read selector together.
// Assumes single-cycle bus accesses and a synchronous active-low reset.
module hio_decoder
    import hio_pkg::*;
#(
    parameter int                    ADDR_W         = 24,
    parameter logic [ADDR_W-1:0]     WIN_BASE       = 24'h180000,
    parameter int                    SND_ADDR_W     = 16,
    parameter logic [SND_ADDR_W-1:0] SND_LATCH_ADDR = 16'hF800
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_rd,
    input  logic                         bus_wr,
    input  logic                         lane_hi,
    input  logic                         lane_lo,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NUM_PADS*DATA_W-1:0]   pad_words,
    input  logic [DATA_W-1:0]            cfg_word,
    input  logic [SND_ADDR_W-1:0]        snd_addr,
    input  logic                         snd_rd,
    input  logic                         snd_ack,
    output logic [BYTE_W-1:0]            snd_rdata,
    output logic                         snd_irq,
    output logic [NUM_SCROLL*DATA_W-1:0] scroll_out,
    output logic [DATA_W-1:0]            fg_bank
);
    hio_hit_t          hit;
    logic [BYTE_W-1:0] cmd_byte;

    hio_addr_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .lane_hi  (lane_hi),
        .hit      (hit)
    );

    hio_reg_bank u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .scroll_wr   (hit.scroll_wr),
        .scroll_idx  (hit.scroll_idx),
        .bank_wr     (hit.bank_wr),
        .lane_hi     (lane_hi),
        .lane_lo     (lane_lo),
        .wdata       (bus_wdata),
        .scroll_flat (scroll_out),
        .fg_bank     (fg_bank)
    );

    hio_cmd_latch #(.SND_ADDR_W(SND_ADDR_W), .SND_LATCH_ADDR(SND_LATCH_ADDR)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (hit.cmd_wr),
        .cmd_data  (bus_wdata[DATA_W-1:BYTE_W]),
        .snd_ack   (snd_ack),
        .snd_addr  (snd_addr),
        .snd_rd    (snd_rd),
        .cmd_byte  (cmd_byte),
        .snd_rdata (snd_rdata),
        .snd_irq   (snd_irq)
    );

    hio_read_mux u_rmux (
        .hit       (hit),
        .pad_words (pad_words),
        .cfg_word  (cfg_word),
        .fg_bank   (fg_bank),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/hio_decoder_chk.sv
// Property checker for hio_decoder, attached by bind. Decodes the command
// and bank addresses independently from the ports.
module hio_decoder_chk #(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'h180000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              lane_hi,
    input logic              lane_lo,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              snd_ack,
    input logic              snd_irq,
    input logic [7:0]        cmd_byte,
    input logic [15:0]       fg_bank
);
    localparam logic [ADDR_W-1:0] CMD_ADDR  = WIN_BASE + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] BANK_ADDR = WIN_BASE + ADDR_W'(28);

    logic cmd_go, bank_go;
    assign cmd_go  = bus_wr && lane_hi && (bus_addr[ADDR_W-1:1] == CMD_ADDR[ADDR_W-1:1]);
    assign bank_go = bus_wr && (lane_hi || lane_lo) &&
                     (bus_addr[ADDR_W-1:1] == BANK_ADDR[ADDR_W-1:1]);

    p_cmd_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> cmd_byte == $past(bus_wdata[15:8]));

    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_go |=> $stable(cmd_byte));

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_irq && !snd_ack) |=> snd_irq);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_ack && !cmd_go) |=> !snd_irq);

    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> snd_irq);

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snd_irq) |-> $past(cmd_go));

    p_bank_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_go |=> $stable(fg_bank));

    // Read data must be zero whenever no read strobe is present.
    always @(negedge clk) begin
        if (rst_n && !bus_rd)
            p_idle_rdata_r4: assert (bus_rdata == 16'h0000);
    end
endmodule

bind hio_decoder hio_decoder_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .lane_hi   (lane_hi),
    .lane_lo   (lane_lo),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .snd_ack   (snd_ack),
    .snd_irq   (snd_irq),
    .cmd_byte  (cmd_byte),
    .fg_bank   (fg_bank)
);

// File: tb/tb_hio_decoder.sv
module tb_hio_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] bus_addr;
    logic        bus_rd, bus_wr, lane_hi, lane_lo;
    logic [15:0] bus_wdata, bus_rdata;
    logic [63:0] pad_words;
    logic [15:0] cfg_word;
    logic [15:0] snd_addr;
    logic        snd_rd, snd_ack;
    logic [7:0]  snd_rdata;
    logic        snd_irq;
    logic [63:0] scroll_out;
    logic [15:0] fg_bank;

    int n_vec = 0;
    int n_bad = 0;

    // Bench model of the storage.
    logic [15:0] m_scr [4];
    logic [15:0] m_bank;
    logic [7:0]  m_latch;
    logic        m_irq;

    always #4 clk = ~clk;

    hio_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .lane_hi(lane_hi), .lane_lo(lane_lo),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_words(pad_words),
        .cfg_word(cfg_word), .snd_addr(snd_addr), .snd_rd(snd_rd),
        .snd_ack(snd_ack), .snd_rdata(snd_rdata), .snd_irq(snd_irq),
        .scroll_out(scroll_out), .fg_bank(fg_bank)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic in_win(input logic [23:0] a);
        return a[23:5] == 19'h0C000;
    endfunction

    function automatic logic [15:0] exp_read(input logic [23:0] a);
        logic [3:0] w;
        w = a[4:1];
        if (!in_win(a)) return 16'h0000;
        if (w < 4) return pad_words[w*16 +: 16];
        if (w == 7) return cfg_word;
        if (w == 14) return m_bank;
        return 16'h0000;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n,
                                          input logic hi, input logic lo);
        logic [15:0] r;
        r = o;
        if (hi) r[15:8] = n[15:8];
        if (lo) r[7:0]  = n[7:0];
        return r;
    endfunction

    // One bus cycle: drive after a falling edge, sample read data, release after the rising edge.
    task automatic bus_cycle(input logic [23:0] a, input logic rd, input logic wr,
                             input logic hi, input logic lo, input logic [15:0] d,
                             input logic ack, output logic [15:0] rdv);
        logic cmd;
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; lane_hi = hi; lane_lo = lo;
        bus_wdata = d; snd_ack = ack;
        #1 rdv = bus_rdata;
        cmd = wr && hi && in_win(a) && a[4:1] == 4'd4;
        if (wr && in_win(a)) begin
            if (cmd) m_latch = d[15:8];
            if (a[4:1] >= 8 && a[4:1] <= 11) m_scr[a[2:1]] = merge(m_scr[a[2:1]], d, hi, lo);
            if (a[4:1] == 14) m_bank = merge(m_bank, d, hi, lo);
        end
        if (cmd) m_irq = 1'b1;
        else if (ack) m_irq = 1'b0;
        @(posedge clk);
        #1;
        bus_rd = 0; bus_wr = 0; lane_hi = 0; lane_lo = 0; snd_ack = 0;
    endtask

    task automatic wr(input logic [23:0] a, input logic [15:0] d, input logic hi,
                      input logic lo, input logic ack);
        logic [15:0] dummy;
        bus_cycle(a, 1'b0, 1'b1, hi, lo, d, ack, dummy);
    endtask

    task automatic rd_chk(input string req, input logic [23:0] a);
        logic [15:0] v;
        bus_cycle(a, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, v);
        chk(req, {48'h0, v}, {48'h0, exp_read(a)});
    endtask

    // Compare every visible piece of state with the model.
    task automatic check_state(input string tag);
        for (int k = 0; k < 4; k++)
            chk({tag, " R10 scroll"}, {48'h0, scroll_out[k*16 +: 16]}, {48'h0, m_scr[k]});
        chk({tag, " R11 bank"}, {48'h0, fg_bank}, {48'h0, m_bank});
        chk({tag, " R7 irq"}, {63'h0, snd_irq}, {63'h0, m_irq});
        snd_rd = 1'b1; snd_addr = 16'hF800;
        #1 chk({tag, " R5 latch"}, {56'h0, snd_rdata}, {56'h0, m_latch});
        snd_addr = 16'hF801;
        #1 chk({tag, " R5 other sound addr"}, {56'h0, snd_rdata}, 64'h0);
        snd_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        rst_n = 0; bus_addr = 0; bus_rd = 0; bus_wr = 0; lane_hi = 0; lane_lo = 0;
        bus_wdata = 0; pad_words = '1; cfg_word = 16'hFFC3; snd_addr = 0;
        snd_rd = 0; snd_ack = 0;
        for (int k = 0; k < 4; k++) m_scr[k] = 16'h0;
        m_bank = 0; m_latch = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        #1 check_state("R1 reset");
        @(negedge clk); rst_n = 1;

        // R2 R3 R4: every window offset under several input patterns.
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < 4; k++)
                pad_words[k*16 +: 16] = (t == 0) ? 16'hFFFF : 16'((k + 1) * 16'h1357 + t * 16'h0F0F) ^ 16'hFFFF;
            cfg_word = 16'(16'hFFC0 | (t * 5));
            for (int w = 0; w < 16; w++)
                rd_chk((w < 4) ? "R2 input word" : (w == 7) ? "R3 cfg word" : "R4 empty offset",
                       24'h180000 + 24'(w * 2));
        end
        rd_chk("R4 below window", 24'h17FFFE);
        rd_chk("R4 above window", 24'h180020);
        rd_chk("R4 far address", 24'h080000);
        bus_cycle(24'h180002, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, v);
        chk("R4 no read strobe", {48'h0, v}, 64'h0);

        // Write sweep: every offset, every lane combination (R6 R9 R10 R11 R5).
        for (int t = 0; t < 2; t++)
            for (int w = 0; w < 16; w++)
                for (int l = 0; l < 4; l++) begin
                    wr(24'h180000 + 24'(w * 2), 16'(w * 16'h0F1 + l * 16'h2200 + t * 16'h05A5) ^ 16'hC3C3,
                       l[1], l[0], 1'b0);
                    check_state((w == 4) ? "R6 cmd lanes" : (w == 5) ? "R9 discard offset" : "R10 R11 sweep");
                    if (m_irq) begin
                        wr(24'h000000, 16'h0, 1'b0, 1'b0, 1'b1);
                        check_state("R7 ack");
                    end
                end
        rd_chk("R11 bank readback", 24'h18001C);

        // R12: writes outside the window.
        wr(24'h190010, 16'hBEEF, 1'b1, 1'b1, 1'b0); check_state("R12 outside");
        wr(24'h080008, 16'hAB12, 1'b1, 1'b1, 1'b0); check_state("R12 outside");
        wr(24'h18003C, 16'h5555, 1'b1, 1'b1, 1'b0); check_state("R12 outside");

        // R7: held interrupt.
        wr(24'h180008, 16'h5A00, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R7 irq held", {63'h0, snd_irq}, 64'h1);
        end
        check_state("R7 held");

        // R8: new command and acknowledge together.
        wr(24'h180008, 16'hA5FF, 1'b1, 1'b1, 1'b1);
        check_state("R8 cmd with ack");
        chk("R8 irq stays", {63'h0, snd_irq}, 64'h1);
        wr(24'h000000, 16'h0, 1'b0, 1'b0, 1'b1);
        check_state("R7 cleared");
        wr(24'h000000, 16'h0, 1'b0, 1'b0, 1'b1);
        check_state("R7 ack idle");

        // R6 specific: lower lane only, interrupt low beforehand.
        wr(24'h180008, 16'h7777, 1'b0, 1'b1, 1'b0);
        check_state("R6 low lane cmd");
        chk("R6 irq low", {63'h0, snd_irq}, 64'h0);

        // R9 specific: discard offset with both lanes.
        wr(24'h18000A, 16'h1234, 1'b1, 1'b1, 1'b0);
        check_state("R9 discard");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule